// File: doc/BRIEF.md
# Multiplierless Transposed-Form FIR Filter

This block is a fixed-coefficient FIR filter that accepts a new sample on every clock and returns one full-precision result per accepted sample. It is built in transposed form. Each accepted sample is scaled by every coefficient in the same cycle, and each of those products is added into its own tap register. The registers form a chain that runs toward the output.

No multipliers are used. The coefficients are set as a parameter vector at elaboration. Each one is recoded into canonical signed digits, where every digit is -1, 0 or +1. Nonzero digits are taken in pairs, and each pair becomes a shared term of the form x + x·2^g or x − x·2^g. That term is built once for the whole filter and reused by every coefficient that needs the same spacing g. Each product is formed as a balanced sum of positive terms minus a balanced sum of negative terms. This keeps the path from input to any product at four adders or fewer.

Cycles with the input strobe low do not advance the filter. The output is therefore the convolution of the accepted samples only. An option registers all products together, which adds one cycle of latency and keeps the taps aligned.

Top module: `fir_csd_transposed`

## Requirements
- R1: With `PIPE`=0, an accepted sample (`in_valid`=1 at a clock edge) produces `out_valid`=1 exactly one edge later. Back-to-back accepted samples give back-to-back results.
- R2: Let x[m] be the m-th accepted sample and c_k the k-th coefficient, where c_0 is `COEF_VEC[COEF_W-1:0]` and it scales the newest sample. The result for sample n is the two's-complement value sum over k of c_k·x[n−k]. Samples from before the last reset count as zero.
- R3: `out_data` is `IN_W+COEF_W+$clog2(TAPS)` bits wide. No tap sum overflows, even for runs of the most negative and most positive input codes in any sign pattern.
- R4: Every product is built only from fixed shifts, additions and subtractions, and it equals the exact product of the sample and its coefficient.
- R5: Each coefficient's signed-digit recoding has no two adjacent nonzero digits and reconstructs the coefficient exactly. Both conditions are checked at elaboration.
- R6: Each shared pair term x ± x·2^g is built at most once and only if some coefficient uses it. The adder depth from input to any product is checked at elaboration to be at most `MAX_DEPTH` (4).
- R7: A cycle with `in_valid`=0 changes no tap state. `out_valid` is 0 and `out_data` holds its value on the following edge, and later results continue the convolution as though the idle cycle had not occurred.
- R8: A synchronous `rst` clears every tap register, the output register and `out_valid` on the next edge.
- R9: With `PIPE`=1, all products are registered together. The result appears two edges after its sample and equals the value given by R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample strobe; the sample is accepted on an edge where this is 1 |
| in_data | input | IN_W | Two's-complement input sample |
| out_valid | output | 1 | A new result is on `out_data` |
| out_data | output | IN_W+COEF_W+$clog2(TAPS) | Two's-complement full-precision result |

## Verification
Two cases are hard to reach from the ports. The first is the widest value the tap chain can ever hold. The stimulus drives the extreme input codes in the sign pattern of the coefficients, in time order, so that every product adds with the same sign when the last sample arrives. The second is tap state lasting across idle gaps and a reset in the middle of the stream. Random data with random gaps is followed by an explicit drain, a reset, and an impulse, and the bench expects that impulse to return the bare coefficients with no residue from before the reset.

// File: rtl/fir_csd_pkg.sv
package fir_csd_pkg;

   typedef enum logic [1:0] {LF_NONE, LF_SHIFT, LF_SUM, LF_DIFF} leaf_kind_e;

   typedef struct packed {
      leaf_kind_e kind;
      logic [7:0] sh;
      logic [7:0] gap;
   } leaf_t;

   // Signed digit of value v at position pos (digits -1, 0, +1).
   function automatic int csd_digit(int v, int w, int pos);
      int r;
      int d;
      r = v;
      for (int i = 0; i <= w; i++) begin
         if ((r & 1) != 0) begin
            d = ((r & 3) == 1) ? 1 : -1;
            r = r - d;
         end else begin
            d = 0;
         end
         if (i == pos) return d;
         r = r >>> 1;
      end
      return 0;
   endfunction

   function automatic int csd_value(int v, int w);
      int acc;
      acc = 0;
      for (int p = 0; p <= w; p++) acc = acc + csd_digit(v, w, p) * (1 << p);
      return acc;
   endfunction

   function automatic bit csd_adjacent_ok(int v, int w);
      for (int p = 0; p < w; p++)
         if (csd_digit(v, w, p) != 0 && csd_digit(v, w, p + 1) != 0) return 1'b0;
      return 1'b1;
   endfunction

   // idx-th leaf of the given side (0 adds, 1 subtracts) for value v.
   function automatic leaf_t leaf_of(int v, int w, int side, int idx);
      int    cnt;
      int    a;
      int    sa;
      int    found;
      int    d;
      leaf_t lf;
      cnt   = 0;
      a     = 0;
      sa    = 0;
      found = 0;
      lf    = '{kind: LF_NONE, sh: 8'd0, gap: 8'd0};
      for (int p = 0; p <= w; p++) begin
         d = csd_digit(v, w, p);
         if (d != 0) begin
            if ((cnt % 2) == 0) begin
               a  = p;
               sa = d;
            end else if (((sa < 0) ? 1 : 0) == side) begin
               if (found == idx) begin
                  lf.kind = (sa * d > 0) ? LF_SUM : LF_DIFF;
                  lf.sh   = 8'(a);
                  lf.gap  = 8'(p - a);
                  return lf;
               end
               found++;
            end
            cnt++;
         end
      end
      if ((cnt % 2) == 1 && ((sa < 0) ? 1 : 0) == side && found == idx) begin
         lf.kind = LF_SHIFT;
         lf.sh   = 8'(a);
      end
      return lf;
   endfunction

   function automatic int side_count(int v, int w, int side);
      int n;
      n = 0;
      for (int i = 0; i <= w; i++)
         if (leaf_of(v, w, side, i).kind != LF_NONE) n++;
      return n;
   endfunction

endpackage

// File: rtl/fir_add_tree.sv
module fir_add_tree #(
   parameter int W   = 16,
   parameter int NUM = 4
) (
   input  logic [NUM-1:0][W-1:0] leaves_i,
   output logic [W-1:0]          sum_o
);
   localparam int LV = $clog2(NUM);

   if ((1 << LV) != NUM) begin : g_bad_num
      $error("fir_add_tree: NUM must be a power of two");
   end

   for (genvar lv = 0; lv <= LV; lv++) begin : g_lv
      localparam int CNT = NUM >> lv;
      logic [CNT-1:0][W-1:0] v;
      if (lv == 0) begin : g_in
         assign v = leaves_i;
      end else begin : g_add
         for (genvar j = 0; j < CNT; j++) begin : g_node
            assign v[j] = g_lv[lv-1].v[2*j] + g_lv[lv-1].v[2*j+1];
         end
      end
   end

   assign sum_o = g_lv[LV].v[0];
endmodule

// File: rtl/fir_csd_net.sv
module fir_csd_net
   import fir_csd_pkg::*;
#(
   parameter int IN_W       = 12,
   parameter int COEF_W     = 10,
   parameter int TAPS       = 8,
   parameter int OUT_W      = 25,
   parameter int MAX_LEAVES = 4,
   parameter int MAX_DEPTH  = 4,
   parameter logic [TAPS*COEF_W-1:0] COEF_VEC = '0
) (
   input  logic [IN_W-1:0]             x_i,
   output logic [TAPS-1:0][OUT_W-1:0]  prod_o
);
   localparam int TREE_LV   = $clog2(MAX_LEAVES);
   localparam int NET_DEPTH = TREE_LV + 2;   // pair term, side tree, final subtract

   function automatic int coef_at(int k);
      return int'($signed(COEF_VEC[k*COEF_W +: COEF_W]));
   endfunction

   function automatic bit gap_used(int g, leaf_kind_e kd);
      leaf_t lf;
      for (int k = 0; k < TAPS; k++)
         for (int s = 0; s < 2; s++)
            for (int i = 0; i < MAX_LEAVES; i++) begin
               lf = leaf_of(coef_at(k), COEF_W, s, i);
               if (lf.kind == kd && int'(lf.gap) == g) return 1'b1;
            end
      return 1'b0;
   endfunction

   // R6: depth bound fixed at elaboration
   if (NET_DEPTH > MAX_DEPTH) begin : g_bad_depth
      $error("fir_csd_net: adder depth exceeds limit");
   end

   logic [OUT_W-1:0] xe;
   assign xe = {{(OUT_W-IN_W){x_i[IN_W-1]}}, x_i};

   // Shared pair terms, one per spacing and sign, only where used (R6).
   logic [OUT_W-1:0] fund_sum [2:COEF_W];
   logic [OUT_W-1:0] fund_dif [2:COEF_W];

   for (genvar g = 2; g <= COEF_W; g++) begin : g_fund
      if (gap_used(g, LF_SUM)) begin : g_s
         assign fund_sum[g] = xe + (xe << g);
      end else begin : g_s0
         assign fund_sum[g] = '0;
      end
      if (gap_used(g, LF_DIFF)) begin : g_d
         assign fund_dif[g] = xe - (xe << g);
      end else begin : g_d0
         assign fund_dif[g] = '0;
      end
   end

   for (genvar k = 0; k < TAPS; k++) begin : g_tap
      localparam int CV = coef_at(k);

      // R5: recoding rules checked on the constant digit tables
      if (!csd_adjacent_ok(CV, COEF_W)) begin : g_bad_adj
         $error("fir_csd_net: adjacent nonzero signed digits");
      end
      if (csd_value(CV, COEF_W) != CV) begin : g_bad_val
         $error("fir_csd_net: signed-digit recoding mismatch");
      end
      if (side_count(CV, COEF_W, 0) > MAX_LEAVES ||
          side_count(CV, COEF_W, 1) > MAX_LEAVES) begin : g_bad_cnt
         $error("fir_csd_net: too many terms for depth bound");
      end

      logic [1:0][MAX_LEAVES-1:0][OUT_W-1:0] leaves;
      logic [1:0][OUT_W-1:0]                 side_sum;

      for (genvar s = 0; s < 2; s++) begin : g_side
         for (genvar i = 0; i < MAX_LEAVES; i++) begin : g_leaf
            localparam leaf_t LF = leaf_of(CV, COEF_W, s, i);
            localparam int    SH = int'(LF.sh);
            localparam int    G  = int'(LF.gap);
            if (LF.kind == LF_SHIFT) begin : g_sh
               assign leaves[s][i] = xe << SH;
            end else if (LF.kind == LF_SUM) begin : g_su
               assign leaves[s][i] = fund_sum[G] << SH;
            end else if (LF.kind == LF_DIFF) begin : g_di
               assign leaves[s][i] = fund_dif[G] << SH;
            end else begin : g_no
               assign leaves[s][i] = '0;
            end
         end

         fir_add_tree #(.W(OUT_W), .NUM(MAX_LEAVES)) tree_i (
            .leaves_i (leaves[s]),
            .sum_o    (side_sum[s])
         );
      end

      assign prod_o[k] = side_sum[0] - side_sum[1];
   end
endmodule

// File: rtl/fir_tap_reg.sv
module fir_tap_reg #(
   parameter int W = 25
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         en_i,
   input  logic [W-1:0] prod_i,
   input  logic [W-1:0] carry_i,
   output logic [W-1:0] acc_o
);
   logic [W-1:0] sum;
   assign sum = prod_i + carry_i;

   always_ff @(posedge clk) begin
      if (rst)       acc_o <= '0;
      else if (en_i) acc_o <= sum;
   end

   // R3: the guard bits keep every tap sum inside the signed range
   p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
      en_i |-> !((prod_i[W-1] == carry_i[W-1]) && (sum[W-1] != prod_i[W-1])));
endmodule

// File: rtl/fir_csd_transposed.sv
module fir_csd_transposed
   import fir_csd_pkg::*;
#(
   parameter int IN_W       = 12,
   parameter int COEF_W     = 10,
   parameter int TAPS       = 8,
   parameter int PIPE       = 0,
   parameter int MAX_LEAVES = 4,
   parameter int MAX_DEPTH  = 4,
   parameter logic [TAPS*COEF_W-1:0] COEF_VEC =
      {-10'sd1, 10'sd17, -10'sd45, 10'sd187, 10'sd255, 10'sd91, -10'sd23, 10'sd5},
   localparam int OUT_W = IN_W + COEF_W + $clog2(TAPS)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic [IN_W-1:0]  in_data,
   output logic             out_valid,
   output logic [OUT_W-1:0] out_data
);
   if (TAPS < 2)                  begin : g_bad_taps $error("TAPS must be at least 2"); end
   if (PIPE != 0 && PIPE != 1)    begin : g_bad_pipe $error("PIPE must be 0 or 1"); end
   if (IN_W < 2 || COEF_W < 3)    begin : g_bad_w    $error("widths too small"); end

   logic [TAPS-1:0][OUT_W-1:0] prod_c;
   logic [TAPS-1:0][OUT_W-1:0] prod_t;
   logic [TAPS-1:0][OUT_W-1:0] acc;
   logic                       adv;

   fir_csd_net #(
      .IN_W(IN_W), .COEF_W(COEF_W), .TAPS(TAPS), .OUT_W(OUT_W),
      .MAX_LEAVES(MAX_LEAVES), .MAX_DEPTH(MAX_DEPTH), .COEF_VEC(COEF_VEC)
   ) net_i (
      .x_i    (in_data),
      .prod_o (prod_c)
   );

   if (PIPE == 1) begin : g_pipe
      logic [TAPS-1:0][OUT_W-1:0] prod_q;
      logic                       v_q;
      always_ff @(posedge clk) begin
         if (rst) begin
            prod_q <= '0;
            v_q    <= 1'b0;
         end else begin
            v_q <= in_valid;
            if (in_valid) prod_q <= prod_c;
         end
      end
      assign prod_t = prod_q;
      assign adv    = v_q;

      // R9: two edges from sample to result
      p_latency_r9: assert property (@(posedge clk) disable iff (rst)
         in_valid |=> ##1 out_valid);
   end else begin : g_comb
      assign prod_t = prod_c;
      assign adv    = in_valid;

      // R1: one edge from sample to result
      p_latency_r1: assert property (@(posedge clk) disable iff (rst)
         in_valid |=> out_valid);
   end

   for (genvar k = 0; k < TAPS; k++) begin : g_chain
      localparam int CV = int'($signed(COEF_VEC[k*COEF_W +: COEF_W]));
      logic [OUT_W-1:0] carry;
      if (k == TAPS - 1) begin : g_last
         assign carry = '0;
      end else begin : g_mid
         assign carry = acc[k+1];
      end

      fir_tap_reg #(.W(OUT_W)) tap_i (
         .clk     (clk),
         .rst     (rst),
         .en_i    (adv),
         .prod_i  (prod_t[k]),
         .carry_i (carry),
         .acc_o   (acc[k])
      );

      // R4: shift-and-add network matches the exact product
      p_product_exact_r4: assert property (@(posedge clk) disable iff (rst)
         prod_c[k] == OUT_W'($signed(OUT_W'($signed(in_data))) * $signed(OUT_W'(CV))));
   end

   always_ff @(posedge clk) begin
      if (rst) out_valid <= 1'b0;
      else     out_valid <= adv;
   end

   assign out_data = acc[0];

   // R7: no advance means a held output and no strobe
   p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
      !adv |=> ($stable(out_data) && !out_valid));

   // R8: reset clears output state on the next edge
   p_reset_clear_r8: assert property (@(posedge clk)
      rst |=> (out_data == '0 && !out_valid));
endmodule

// File: tb/fir_csd_transposed_tb.sv
`timescale 1ns/1ps
module fir_csd_transposed_tb_top;
   localparam int IN_W  = 12;
   localparam int TAPS  = 8;
   localparam int OUT_W = 25;

   typedef struct {
      longint exp;
      int     cyc;
      string  tag;
   } item_t;

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic             in_valid = 1'b0;
   logic [IN_W-1:0]  in_data = '0;
   logic             o0_v, o1_v;
   logic [OUT_W-1:0] o0_d, o1_d;

   int     cf [TAPS] = '{5, -23, 91, 255, 187, -45, 17, -1};
   longint hist [TAPS];
   item_t  q0 [$];
   item_t  q1 [$];
   int     cyc = 0;
   int     checks = 0;
   int     errors = 0;
   string  cur_tag = "R2";

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   fir_csd_transposed #(.PIPE(0)) dut_i (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
      .out_valid(o0_v), .out_data(o0_d));

   fir_csd_transposed #(.PIPE(1)) dut_p (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
      .out_valid(o1_v), .out_data(o1_d));

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Driver: applies one cycle of input and pushes expected results.
   task automatic drive(input bit v, input logic signed [IN_W-1:0] x);
      item_t it;
      longint s;
      @(negedge clk);
      in_valid = v;
      in_data  = x;
      if (v) begin
         for (int i = TAPS - 1; i > 0; i--) hist[i] = hist[i-1];
         hist[0] = longint'(x);
         s = 0;
         for (int i = 0; i < TAPS; i++) s += longint'(cf[i]) * hist[i];
         it.exp = s;
         it.cyc = cyc;
         it.tag = cur_tag;
         q0.push_back(it);
         q1.push_back(it);
      end
   endtask

   // Monitors: pop and compare value and latency.
   always @(negedge clk) begin
      if (!rst && o0_v) begin
         if (q0.size() == 0) check(1'b0, "R1 unexpected result", 1, 0);
         else begin
            item_t it;
            it = q0.pop_front();
            check(longint'($signed(o0_d)) == it.exp, it.tag, longint'($signed(o0_d)), it.exp);
            check(cyc - it.cyc == 1, "R1 latency", cyc - it.cyc, 1);
         end
      end
      if (!rst && o1_v) begin
         if (q1.size() == 0) check(1'b0, "R9 unexpected result", 1, 0);
         else begin
            item_t it;
            it = q1.pop_front();
            check(longint'($signed(o1_d)) == it.exp, {"R9 ", it.tag}, longint'($signed(o1_d)), it.exp);
            check(cyc - it.cyc == 2, "R9 latency", cyc - it.cyc, 2);
         end
      end
   end

   task automatic do_reset();
      for (int i = 0; i < 3; i++) drive(1'b0, '0);
      @(negedge clk);
      rst = 1'b1;
      for (int i = 0; i < TAPS; i++) hist[i] = 0;
      @(negedge clk);
      // R8: one reset edge has cleared both outputs
      check(o0_d == '0 && !o0_v, "R8 reset clear", longint'(o0_d), 0);
      check(o1_d == '0 && !o1_v, "R8 reset clear piped", longint'(o1_d), 0);
      @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      #(200000 * 5.0);
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      finish_run();
   end

   initial begin
      logic [OUT_W-1:0] held;
      for (int i = 0; i < TAPS; i++) hist[i] = 0;
      repeat (3) @(negedge clk);
      check(o0_d == '0 && !o0_v, "R8 initial reset", longint'(o0_d), 0);
      rst = 1'b0;

      // R4 R5 R6: impulse returns each coefficient exactly
      cur_tag = "R4 impulse";
      drive(1'b1, 12'sd1);
      for (int i = 0; i < TAPS + 2; i++) drive(1'b1, '0);

      // R2: step and ramp
      cur_tag = "R2 step";
      for (int i = 0; i < 12; i++) drive(1'b1, 12'sd100);
      cur_tag = "R2 ramp";
      for (int i = 0; i < 20; i++) drive(1'b1, 12'(i * 97 - 900));

      // R3: extreme codes, constant and sign-aligned with the coefficients
      cur_tag = "R3 max";
      for (int i = 0; i < 10; i++) drive(1'b1, 12'sd2047);
      cur_tag = "R3 min";
      for (int i = 0; i < 10; i++) drive(1'b1, -12'sd2048);
      cur_tag = "R3 aligned";
      for (int r = 0; r < 3; r++) begin
         for (int i = TAPS - 1; i >= 0; i--)
            drive(1'b1, (cf[i] < 0) ? -12'sd2048 : 12'sd2047);
         for (int i = TAPS - 1; i >= 0; i--)
            drive(1'b1, (cf[i] < 0) ? 12'sd2047 : -12'sd2048);
      end

      // R7: idle cycles hold the output and leave taps untouched
      cur_tag = "R7 resume";
      drive(1'b1, 12'sd321);
      drive(1'b1, -12'sd77);
      drive(1'b0, '0);
      held = o0_d;
      for (int i = 0; i < 4; i++) begin
         drive(1'b0, 12'sd1234);
         check(o0_d == held && !o0_v, "R7 idle hold", longint'(o0_d), longint'(held));
      end
      for (int i = 0; i < 10; i++) drive(1'b1, 12'(i * 211));

      // R1 R2: random samples with random gaps
      cur_tag = "R2 random";
      for (int i = 0; i < 300; i++) drive(($urandom_range(0, 3) != 0), 12'($urandom));
      drive(1'b1, 12'sd2047);
      drive(1'b1, -12'sd2048);

      // R8: reset mid-stream, then impulse shows no residue
      do_reset();
      cur_tag = "R8 post-reset impulse";
      drive(1'b1, -12'sd3);
      for (int i = 0; i < TAPS + 2; i++) drive(1'b1, '0);
      for (int i = 0; i < 4; i++) drive(1'b0, '0);

      check(q0.size() == 0, "R1 results outstanding", q0.size(), 0);
      check(q1.size() == 0, "R9 results outstanding", q1.size(), 0);
      finish_run();
   end
endmodule